// File: doc/BRIEF.md
# Descriptor-Driven Infrared Carrier Transmitter

This block produces the waveform for an infrared LED from a queue of timing words. Each 32-bit word describes one symbol. A symbol is either a burst of carrier or a steady stretch with no carrier, and the word gives its length in periods. The words wait in an internal 32-entry queue. A producer writes them through a valid/ready port. The queue accepts a word on any clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls only when the queue is full. A producer may hold a word at any time, because the port has no timeout.

The carrier comes from the system clock. Its period and its high time are both set in clock cycles. The carrier phase restarts at the first cycle of every symbol. A separate compensation tick, with its own period, can time no-carrier symbols instead of the carrier period. A two-bit output-type setting can invert the symbol envelope, the carrier, or both. A further setting picks the level driven while the engine is idle. Three interrupt outputs report queue empty, fill at or below a threshold, and a word refused because the queue was full.

Descriptor layout:
- bit 31 = carrier on.
- bit 30 = last symbol of a frame.
- bits 29:28 = timing mode.
- bits 27:0 = period count.

Top module: `irtx_engine`

## Requirements
- R1: While reset is applied and in the first cycle after it, `tx_out` is 0, `busy` is 0, `wr_ready` is 1, `free_cnt` equals the depth (32) and `irq_empty` is 1.
- R2: For a descriptor with bit 31 = 1 and count N, the symbol lasts N×P cycles, where P = `cfg_period`. Within each period, the carrier is high for the first `cfg_high` cycles. The first period is aligned to the first cycle of the symbol.
- R3: For a descriptor with bit 31 = 0, timing mode 0 and count N, `tx_out` (with the normal output type) holds 0 for N×P cycles.
- R4: Timing mode 3 (bits 29:28 = 2'b11) on a no-carrier descriptor times the symbol in compensation ticks: N×D cycles, where D = `cfg_alt_div`. Timing mode 3 on a carrier descriptor has no effect. Timing modes 1 and 2 behave as mode 0.
- R5: A descriptor with bit 30 = 1 is sent in full and then the engine stops. `tx_out` shows the idle level for exactly one cycle before a frame already queued behind it starts, while `tx_en` stays high.
- R6: `cfg_out_type` bit 1 inverts the symbol envelope and bit 0 inverts the carrier. `tx_out` = (carrier_bit ^ type[1]) ? (wave ^ type[0]) : 0.
- R7: While not busy, `tx_out` follows `cfg_idle_high`, one cycle later.
- R8: If a symbol without bit 30 ends while the queue is empty, the engine goes idle at once and `tx_out` returns to the idle level. `irq_empty` is then high.
- R9: `irq_level` is high exactly when the queue fill is less than or equal to `cfg_level`.
- R10: `irq_empty` is high whenever the queue is empty. `irq_ovf` pulses high for one cycle after each cycle in which `wr_valid` was high while the queue was full. Such a word is not stored.
- R11: `wr_ready` is low only when the queue is full. `free_cnt` equals 32 minus the number of stored words. A write and a descriptor fetch on the same edge leave the fill unchanged.
- R12: A count field of 0 is timed as a count of 1.
- R13: No descriptor is taken from the queue while `tx_en` is low and the engine is idle. The first symbol appears on `tx_out` two edges after the edge that samples `tx_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Descriptor offered |
| wr_ready | output | 1 | Queue can take a descriptor |
| wr_data | input | 32 | Descriptor word |
| tx_en | input | 1 | Allow the engine to start a frame |
| cfg_period | input | PW (16) | Carrier period in clock cycles |
| cfg_high | input | PW (16) | Carrier high time in clock cycles |
| cfg_alt_div | input | PW (16) | Compensation tick period in clock cycles |
| cfg_out_type | input | 2 | Bit 1 inverts the envelope, bit 0 inverts the carrier |
| cfg_idle_high | input | 1 | Idle output level |
| cfg_level | input | CW (6) | Fill threshold for `irq_level` |
| tx_out | output | 1 | Infrared drive pin |
| busy | output | 1 | A symbol is being sent |
| free_cnt | output | CW (6) | Unused queue entries |
| irq_empty | output | 1 | Queue empty |
| irq_level | output | 1 | Fill at or below threshold |
| irq_ovf | output | 1 | Word refused on a full queue |

## Verification
Two things can land on the same clock edge. A producer can write a word on the very edge where the engine fetches the next descriptor, either at the start of a frame or at a symbol boundary. The bench forces this by raising `wr_valid` in the cycle where `tx_en` first starts a queued frame. It then checks that `free_cnt` is unchanged by the combined push and fetch. It also offers a word while the queue is full and checks that the word is refused and `irq_ovf` pulses. Randomized frames then compare `tx_out` cycle by cycle with a waveform built in the bench from the descriptor fields, mixing carrier periods, compensation ticks, zero counts and output types.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam int DESC_W = 32;
  localparam int CNT_W  = 28;

  typedef struct packed {
    logic             carrier;
    logic             last;
    logic [1:0]       timing;
    logic [CNT_W-1:0] count;
  } irtx_desc_t;

  localparam logic [1:0] TIMING_ALT = 2'b11;
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    fill
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;

  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

  assert_fill_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (fill == $past(fill) + 1'b1));
  assert_fill_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (fill == $past(fill) - 1'b1));
endmodule

// File: rtl/irtx_phase.sv
module irtx_phase #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] limit_m1,
  output logic [PW-1:0] phase,
  output logic          wrap
);
  assign wrap = (phase >= limit_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)               phase <= '0;
    else if (restart || wrap) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  assert_restart_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0));
endmodule

// File: rtl/irtx_seq.sv
module irtx_seq import irtx_pkg::*; #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  irtx_desc_t    head,
  input  logic          fifo_empty,
  input  logic          car_wrap,
  input  logic [PW-1:0] alt_lim,
  output logic          load,
  output logic          run,
  output logic          cur_carrier
);
  logic             cur_last, cur_alt;
  logic [CNT_W-1:0] remain;
  logic [PW-1:0]    alt_cnt;
  logic             alt_wrap, tick, sym_end;

  assign alt_wrap = (alt_cnt >= alt_lim);
  assign tick     = run && (cur_alt ? alt_wrap : car_wrap);
  assign sym_end  = tick && (remain == CNT_W'(1));
  assign load     = !fifo_empty && ((!run && tx_en) || (sym_end && !cur_last));

  always_ff @(posedge clk) begin
    if (!rst_n)                alt_cnt <= '0;
    else if (load || alt_wrap) alt_cnt <= '0;
    else                       alt_cnt <= alt_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run         <= 1'b0;
      cur_carrier <= 1'b0;
      cur_last    <= 1'b0;
      cur_alt     <= 1'b0;
      remain      <= '0;
    end else if (load) begin
      run         <= 1'b1;
      cur_carrier <= head.carrier;
      cur_last    <= head.last;
      cur_alt     <= !head.carrier && (head.timing == TIMING_ALT);
      remain      <= (head.count == '0) ? CNT_W'(1) : head.count;
    end else if (sym_end) begin
      run <= 1'b0;
    end else if (tick) begin
      remain <= remain - 1'b1;
    end
  end

  assert_stop_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_end && cur_last) |=> !run);
  assert_underrun_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_end && fifo_empty) |=> !run);
  assert_alt_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && head.carrier) |=> !cur_alt);
endmodule

// File: rtl/irtx_shaper.sv
module irtx_shaper #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          carrier,
  input  logic [PW-1:0] phase,
  input  logic [PW-1:0] high,
  input  logic [1:0]    out_type,
  input  logic          idle_high,
  output logic          tx_out
);
  logic wave, env, nxt;

  assign wave = (phase < high) ^ out_type[0];
  assign env  = carrier ^ out_type[1];
  assign nxt  = run ? (env & wave) : idle_high;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_out <= 1'b0;
    else        tx_out <= nxt;
  end

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tx_out == $past(idle_high)));
endmodule

// File: rtl/irtx_engine.sv
module irtx_engine import irtx_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int PW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [31:0]   wr_data,
  input  logic          tx_en,
  input  logic [PW-1:0] cfg_period,
  input  logic [PW-1:0] cfg_high,
  input  logic [PW-1:0] cfg_alt_div,
  input  logic [1:0]    cfg_out_type,
  input  logic          cfg_idle_high,
  input  logic [CW-1:0] cfg_level,
  output logic          tx_out,
  output logic          busy,
  output logic [CW-1:0] free_cnt,
  output logic          irq_empty,
  output logic          irq_level,
  output logic          irq_ovf
);
  logic              full, empty, push, load, run, cur_car, car_wrap;
  logic [CW-1:0]     fill;
  logic [DESC_W-1:0] head_w;
  logic [PW-1:0]     car_phase, car_lim, alt_lim;

  assign wr_ready  = !full;
  assign push      = wr_valid && wr_ready;
  assign car_lim   = (cfg_period  == '0) ? '0 : cfg_period  - 1'b1;
  assign alt_lim   = (cfg_alt_div == '0) ? '0 : cfg_alt_div - 1'b1;
  assign busy      = run;
  assign free_cnt  = CW'(DEPTH) - fill;
  assign irq_empty = empty;
  assign irq_level = (fill <= cfg_level);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_ovf <= 1'b0;
    else        irq_ovf <= wr_valid && full;
  end

  irtx_fifo #(.DEPTH(DEPTH), .WIDTH(DESC_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(wr_data), .pop(load),
    .rdata(head_w), .empty(empty), .full(full), .fill(fill)
  );

  irtx_seq #(.PW(PW)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .head(irtx_desc_t'(head_w)),
    .fifo_empty(empty), .car_wrap(car_wrap), .alt_lim(alt_lim),
    .load(load), .run(run), .cur_carrier(cur_car)
  );

  irtx_phase #(.PW(PW)) u_carrier (
    .clk(clk), .rst_n(rst_n), .restart(load), .limit_m1(car_lim),
    .phase(car_phase), .wrap(car_wrap)
  );

  irtx_shaper #(.PW(PW)) u_shaper (
    .clk(clk), .rst_n(rst_n), .run(run), .carrier(cur_car), .phase(car_phase),
    .high(cfg_high), .out_type(cfg_out_type), .idle_high(cfg_idle_high),
    .tx_out(tx_out)
  );

  assert_ovf_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> ($past(wr_valid) && ($past(free_cnt) == '0)));
  assert_ready_when_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt != '0) |-> wr_ready);
endmodule

// File: tb/irtx_engine_bench.sv
module irtx_engine_bench;
  localparam int DEPTH = 32;
  localparam int PW    = 16;
  localparam int CW    = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [31:0]   wr_data = '0;
  logic          tx_en = 1'b0;
  logic [1:0]    otype = 2'b00;
  logic          idle = 1'b0;
  logic [CW-1:0] level = '0;
  logic          tx_out, busy, irq_empty, irq_level, irq_ovf;
  logic [CW-1:0] free_cnt;
  int per = 4, hi = 2, alt = 3;
  int checks = 0, errors = 0;
  bit done = 0;
  logic exp_w [0:1023];
  int exp_n = 0;

  always #5 clk = ~clk;

  irtx_engine #(.DEPTH(DEPTH), .PW(PW)) u_irtx_engine (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .tx_en(tx_en), .cfg_period(PW'(per)), .cfg_high(PW'(hi)),
    .cfg_alt_div(PW'(alt)), .cfg_out_type(otype), .cfg_idle_high(idle),
    .cfg_level(level), .tx_out(tx_out), .busy(busy), .free_cnt(free_cnt),
    .irq_empty(irq_empty), .irq_level(irq_level), .irq_ovf(irq_ovf)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit c, input bit l, input logic [1:0] m, input int n);
    return {c, l, m, 28'(n)};
  endfunction

  task automatic add_sym(input logic [31:0] d);
    int n, len;
    bit wave, env;
    n   = (d[27:0] == 0) ? 1 : int'(d[27:0]);
    len = (!d[31] && d[29:28] == 2'b11) ? alt : per;
    for (int i = 0; i < n * len; i++) begin
      wave = ((i % per) < hi);
      env  = d[31] ^ otype[1];
      exp_w[exp_n] = env ? (wave ^ otype[0]) : 1'b0;
      exp_n++;
    end
  endtask

  task automatic add_gap();
    exp_w[exp_n] = idle;
    exp_n++;
  endtask

  task automatic push(input logic [31:0] w);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic queue_sym(input logic [31:0] w);
    push(w);
    add_sym(w);
  endtask

  task automatic run_frame(input string tag);
    int bad;
    logic e;
    bad = 0;
    tx_en = 1'b1;
    for (int i = 0; i < exp_n + 2; i++) begin
      @(negedge clk);
      e = (i == 0 || i == exp_n + 1) ? idle : exp_w[i-1];
      if (tx_out !== e) bad++;
    end
    tx_en = 1'b0;
    chk(bad == 0, tag, bad, 0);
    exp_n = 0;
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed, nd, cnt;
    logic [31:0] w;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(tx_out == 1'b0 && busy == 1'b0, "R1 out/busy in reset", tx_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_out == 1'b0, "R1 tx_out", tx_out, 0);
    chk(wr_ready == 1'b1 && irq_empty == 1'b1, "R1 ready/empty", {wr_ready, irq_empty}, 3);
    chk(free_cnt == CW'(DEPTH), "R1 free_cnt", free_cnt, DEPTH);

    // R2/R3: long carrier burst followed by a no-carrier gap
    per = 4; hi = 2;
    queue_sym(mk(1, 0, 2'd0, 21));
    queue_sym(mk(0, 1, 2'd0, 63));
    run_frame("R2 R3 burst and gap");

    // R4: compensation timing; ignored on carrier, modes 1/2 as 0
    per = 3; hi = 1; alt = 7;
    queue_sym(mk(0, 0, 2'd3, 3));
    queue_sym(mk(1, 0, 2'd3, 2));
    queue_sym(mk(0, 0, 2'd1, 2));
    queue_sym(mk(1, 1, 2'd2, 1));
    run_frame("R4 timing modes");

    // R12: zero count lasts one period
    queue_sym(mk(1, 0, 2'd0, 0));
    queue_sym(mk(0, 1, 2'd3, 0));
    run_frame("R12 zero count");

    // R5: two queued frames, one idle cycle between
    per = 2; hi = 1;
    queue_sym(mk(1, 1, 2'd0, 3));
    add_gap();
    queue_sym(mk(1, 0, 2'd0, 2));
    queue_sym(mk(0, 1, 2'd0, 1));
    run_frame("R5 frame gap");

    // R6: all output types
    per = 4; hi = 3;
    for (int t = 0; t < 4; t++) begin
      otype = 2'(t);
      queue_sym(mk(1, 0, 2'd0, 2));
      queue_sym(mk(0, 1, 2'd0, 2));
      run_frame($sformatf("R6 output type %0d", t));
    end
    otype = 2'b00;

    // R7: idle high
    idle = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_out == 1'b1, "R7 idle high level", tx_out, 1);
    queue_sym(mk(1, 1, 2'd0, 2));
    run_frame("R7 frame with idle high");
    idle = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_out == 1'b0, "R7 idle low level", tx_out, 0);

    // R8: underrun
    queue_sym(mk(1, 0, 2'd0, 3));
    run_frame("R8 underrun waveform");
    chk(busy == 1'b0 && irq_empty == 1'b1, "R8 idle and empty", {busy, irq_empty}, 1);

    // R13: no fetch without tx_en
    w = mk(1, 1, 2'd0, 2);
    push(w);
    repeat (10) @(negedge clk);
    chk(free_cnt == CW'(DEPTH - 1) && busy == 1'b0, "R13 held without tx_en", free_cnt, DEPTH - 1);
    chk(tx_out == idle, "R13 output idle", tx_out, idle);
    add_sym(w);
    run_frame("R13 start latency");

    // R9/R10/R11: threshold, full, overflow
    per = 1; hi = 1; level = 6'd3;
    for (int k = 0; k < 3; k++) push(mk(0, 1, 2'd0, 1));
    chk(irq_level == 1'b1, "R9 fill 3 at threshold", irq_level, 1);
    chk(irq_empty == 1'b0, "R10 not empty", irq_empty, 0);
    push(mk(0, 1, 2'd0, 1));
    chk(irq_level == 1'b0, "R9 fill 4 above threshold", irq_level, 0);
    for (int k = 4; k < DEPTH; k++) push(mk(0, 1, 2'd0, 1));
    chk(free_cnt == '0 && wr_ready == 1'b0, "R11 full", {free_cnt, wr_ready}, 0);
    wr_valid = 1'b1;
    wr_data  = mk(1, 1, 2'd0, 9);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(irq_ovf == 1'b1, "R10 overflow pulse", irq_ovf, 1);
    chk(free_cnt == '0, "R10 refused word not stored", free_cnt, 0);
    @(negedge clk);
    chk(irq_ovf == 1'b0, "R10 overflow one cycle", irq_ovf, 0);
    tx_en = 1'b1;
    repeat (200) @(negedge clk);
    tx_en = 1'b0;
    chk(free_cnt == CW'(DEPTH) && irq_empty == 1'b1, "R10 drained empty", free_cnt, DEPTH);

    // R11: push and fetch on the same edge
    per = 3;
    push(mk(0, 1, 2'd0, 2));
    push(mk(0, 1, 2'd0, 2));
    tx_en    = 1'b1;
    wr_valid = 1'b1;
    wr_data  = mk(0, 1, 2'd0, 2);
    @(negedge clk);
    wr_valid = 1'b0;
    chk(free_cnt == CW'(DEPTH - 2), "R11 push with fetch", free_cnt, DEPTH - 2);
    repeat (60) @(negedge clk);
    tx_en = 1'b0;
    chk(free_cnt == CW'(DEPTH), "R11 drained", free_cnt, DEPTH);

    // Random frames (R2 R3 R4 R6 R12)
    for (int f = 0; f < 40; f++) begin
      per   = 1 + int'($urandom_range(5));
      hi    = int'($urandom_range(per));
      alt   = 1 + int'($urandom_range(4));
      otype = 2'($urandom_range(3));
      idle  = 1'($urandom_range(1));
      repeat (2) @(negedge clk);
      nd = 1 + int'($urandom_range(3));
      for (int d = 0; d < nd; d++) begin
        cnt = int'($urandom_range(5));
        queue_sym(mk(1'($urandom_range(1)), d == nd - 1, 2'($urandom_range(3)), cnt));
      end
      run_frame($sformatf("R2 R4 R6 random frame %0d", f));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule